// File: doc/BRIEF.md
# Dual-Core Interrupt Aggregation Controller

This block gathers a set of level-sensitive, active-high interrupt sources and fans them out to four output lines: one ordinary interrupt line and one machine-check line for each of two processor cores. Every output has its own enable mask register. An output is raised while any source that its mask enables is high. The masks are independent of one another, so a single source may drive several outputs at the same time.

The block does not latch or acknowledge anything. A line falls as soon as the enabled source levels fall, or when software clears the mask bits that enable them. Software reads the live, synchronised source levels through a read-only status register. It programs the masks through a simple 32-bit register bus that uses byte addresses and registered read data.

Top module: `intAggregator`

## Requirements
- R1: After reset all four mask registers read as zero, all four output lines are low and the read data bus is zero.
- R2: A read at offset 0x00 returns the synchronised source levels, with bit n holding source n. Read data appears on `busRdata` after the clock edge that samples the read and holds until the next read.
- R3: The interrupt mask for core c is read/write at byte offset 0x10 + 4*c (0x10 for core 0, 0x14 for core 1). A written value reads back unchanged, and a mask changes only when its own offset is written.
- R4: The machine-check mask for core c is read/write at byte offset 0x18 + 4*c (0x18 for core 0, 0x1C for core 1). A written value reads back unchanged, and a mask changes only when its own offset is written.
- R5: Each output line is registered and equals the OR of (status AND its own mask), where a mask bit of 1 enables the source. After a mask write it takes the new value one clock after the write edge.
- R6: The masks are not exclusive. A source enabled in several masks raises all of those outputs together.
- R7: Outputs are not latched. A change at a source input reaches the outputs on the third rising clock edge (two synchroniser flops plus the output flop), and a line falls when its enabled sources fall.
- R8: Writes to offset 0x00, to unmapped offsets and to unaligned offsets change no register. Reads from unmapped or unaligned offsets return zero.
- R9: The upper sources, including bit 31, behave the same as the lower ones in status, masking and output generation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcIrq | input | 32 | Level-sensitive interrupt sources, active high, asynchronous |
| busEn | input | 1 | Register access strobe, one cycle per access |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte address of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| coreIrq | output | 2 | Interrupt line per core |
| coreMchk | output | 2 | Machine-check line per core |

## Verification
The hardest case to reach from the ports is a source whose level is still high when it loses its enable. The output must then fall only because of the mask write, one clock after the write edge. The stimulus holds a source high with its enable set, rewrites that mask to zero, and samples the line on the cycle before the fall and on the cycle of the fall. Overlapping enables are also set up on purpose so that one source lights a core interrupt line and the other core's machine-check line together. The three-edge latency from the source pins is measured on both the rising and the falling source edge.

// File: rtl/intAggPkg.sv
package intAggPkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned CORES  = 2;
  localparam int unsigned IDX_W  = (CORES > 1) ? $clog2(CORES) : 1;

  typedef enum logic [1:0] {
    RD_NONE,
    RD_STATUS,
    RD_INTMASK,
    RD_MCHKMASK
  } rdSel_e;

  // strobes from the decoder to the datapath
  typedef struct packed {
    logic [CORES-1:0] wrInt;
    logic [CORES-1:0] wrMchk;
    logic             rdEn;
    rdSel_e           rdSel;
    logic [IDX_W-1:0] rdIdx;
  } ctrlStrobe_t;
endpackage

// File: rtl/intAggSync.sv
module intAggSync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stageQ [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[s] <= '0;
        else       stageQ[s] <= asyncIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[s] <= '0;
        else       stageQ[s] <= stageQ[s-1];
      end
    end
  end

  assign syncOut = stageQ[STAGES-1];
endmodule

// File: rtl/intAggCtrl.sv
module intAggCtrl
  import intAggPkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned STATUS_OFF = 'h00,
  parameter int unsigned INT_BASE   = 'h10,
  parameter int unsigned REG_STRIDE = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busEn,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrlStrobe_t       strobe
);
  localparam int unsigned MCHK_BASE = INT_BASE + REG_STRIDE * CORES;

  always_comb begin
    strobe       = '0;
    strobe.rdSel = RD_NONE;
    strobe.rdEn  = busEn && !busWe;
    if (busAddr == ADDR_W'(STATUS_OFF)) begin
      strobe.rdSel = RD_STATUS;
    end
    for (int c = 0; c < CORES; c++) begin
      if (busAddr == ADDR_W'(INT_BASE + c * REG_STRIDE)) begin
        strobe.rdSel    = RD_INTMASK;
        strobe.rdIdx    = IDX_W'(c);
        strobe.wrInt[c] = busEn && busWe;
      end
      if (busAddr == ADDR_W'(MCHK_BASE + c * REG_STRIDE)) begin
        strobe.rdSel     = RD_MCHKMASK;
        strobe.rdIdx     = IDX_W'(c);
        strobe.wrMchk[c] = busEn && busWe;
      end
    end
  end

  AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrInt, strobe.wrMchk})); // R3

  AST_RD_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdEn |-> !(|{strobe.wrInt, strobe.wrMchk})); // R8
endmodule

// File: rtl/intAggDatapath.sv
module intAggDatapath
  import intAggPkg::*;
#(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_SRC-1:0] srcSync,
  output logic [DATA_W-1:0]  rdData,
  output logic [CORES-1:0]   coreIrq,
  output logic [CORES-1:0]   coreMchk
);
  logic [NUM_SRC-1:0] intMask  [CORES];
  logic [NUM_SRC-1:0] mchkMask [CORES];
  logic [DATA_W-1:0]  rdNext;

  for (genvar c = 0; c < CORES; c++) begin : g_core
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 intMask[c] <= '0;
      else if (strobe.wrInt[c])  intMask[c] <= wrData[NUM_SRC-1:0];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 mchkMask[c] <= '0;
      else if (strobe.wrMchk[c]) mchkMask[c] <= wrData[NUM_SRC-1:0];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        coreIrq[c]  <= 1'b0;
        coreMchk[c] <= 1'b0;
      end else begin
        coreIrq[c]  <= |(srcSync & intMask[c]);
        coreMchk[c] <= |(srcSync & mchkMask[c]);
      end
    end

    AST_INT_MASK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      !strobe.wrInt[c] |=> $stable(intMask[c])); // R3
    AST_MCHK_MASK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      !strobe.wrMchk[c] |=> $stable(mchkMask[c])); // R4
  end

  always_comb begin
    rdNext = '0;
    unique case (strobe.rdSel)
      RD_STATUS:   rdNext = DATA_W'(srcSync);
      RD_INTMASK:  rdNext = DATA_W'(intMask[strobe.rdIdx]);
      RD_MCHKMASK: rdNext = DATA_W'(mchkMask[strobe.rdIdx]);
      default:     rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rdData <= '0;
    else if (strobe.rdEn) rdData <= rdNext;
  end

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdEn && strobe.rdSel == RD_NONE) |=> rdData == '0); // R8

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rdEn |=> $stable(rdData)); // R2

  AST_QUIET_NO_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    (srcSync == '0) |=> (coreIrq == '0 && coreMchk == '0)); // R7
endmodule

// File: rtl/intAggregator.sv
module intAggregator
  import intAggPkg::*;
#(
  parameter int unsigned NUM_SRC     = 32,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned STATUS_OFF  = 'h00,
  parameter int unsigned INT_BASE    = 'h10,
  parameter int unsigned REG_STRIDE  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIrq,
  input  logic               busEn,
  input  logic               busWe,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  output logic [CORES-1:0]   coreIrq,
  output logic [CORES-1:0]   coreMchk
);
  logic [NUM_SRC-1:0] srcSync;
  ctrlStrobe_t        strobe;

  intAggSync #(
    .WIDTH  (NUM_SRC),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (srcIrq),
    .syncOut (srcSync)
  );

  intAggCtrl #(
    .ADDR_W     (ADDR_W),
    .STATUS_OFF (STATUS_OFF),
    .INT_BASE   (INT_BASE),
    .REG_STRIDE (REG_STRIDE)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busEn   (busEn),
    .busWe   (busWe),
    .busAddr (busAddr),
    .strobe  (strobe)
  );

  intAggDatapath #(
    .NUM_SRC (NUM_SRC)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (busWdata),
    .srcSync  (srcSync),
    .rdData   (busRdata),
    .coreIrq  (coreIrq),
    .coreMchk (coreMchk)
  );
endmodule

// File: tb/intAggregator_tb.sv
`timescale 1ns/1ps
module intAggregator_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] srcIrq = '0;
  logic        busEn = 1'b0;
  logic        busWe = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [1:0]  coreIrq;
  logic [1:0]  coreMchk;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } expItem_t;
  expItem_t expQ[$];

  always #2 clk = ~clk;

  intAggregator u_dut (
    .clk(clk), .rstN(rstN), .srcIrq(srcIrq), .busEn(busEn), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .coreIrq(coreIrq), .coreMchk(coreMchk)
  );

  // monitor: compares read data one clock after the read was sampled
  always @(posedge clk) begin
    if (rstN && busEn && !busWe) begin
      #1;
      if (expQ.size() == 0) begin
        fails++;
        $display("FAIL scoreboard: read with no expected item, actual %h", busRdata);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        checks++;
        if (busRdata !== it.exp) begin
          fails++;
          $display("FAIL %s: rdata actual %h expected %h", it.tag, busRdata, it.exp);
        end
      end
    end
  end

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busEn = 1'b1; busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busEn = 1'b0; busWe = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, input logic [31:0] e, input string tag);
    expItem_t it;
    it.exp = e; it.tag = tag;
    expQ.push_back(it);
    @(negedge clk);
    busEn = 1'b1; busWe = 1'b0; busAddr = a;
    @(negedge clk);
    busEn = 1'b0;
  endtask

  task automatic checkLines(input logic [1:0] eIrq, input logic [1:0] eMchk, input string tag);
    checks++;
    if (coreIrq !== eIrq || coreMchk !== eMchk) begin
      fails++;
      $display("FAIL %s: irq/mchk actual %b/%b expected %b/%b", tag, coreIrq, coreMchk, eIrq, eMchk);
    end
  endtask

  task automatic setSrc(input logic [31:0] v);
    @(negedge clk);
    srcIrq = v;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    checks++;
    if (busRdata !== 32'h0) begin
      fails++;
      $display("FAIL R1: rdata actual %h expected %h", busRdata, 32'h0);
    end
    checkLines(2'b00, 2'b00, "R1 reset lines");
    rstN = 1'b1;
    busRead(8'h10, 32'h0, "R1 int mask 0");
    busRead(8'h14, 32'h0, "R1 int mask 1");
    busRead(8'h18, 32'h0, "R1 mchk mask 0");
    busRead(8'h1C, 32'h0, "R1 mchk mask 1");

    // R3 / R4 readback of distinct patterns
    busWrite(8'h10, 32'hA5A5_0F0F);
    busWrite(8'h14, 32'h1234_5678);
    busWrite(8'h18, 32'hDEAD_BEEF);
    busWrite(8'h1C, 32'h0F0F_F0F0);
    busRead(8'h10, 32'hA5A5_0F0F, "R3 int mask 0");
    busRead(8'h14, 32'h1234_5678, "R3 int mask 1");
    busRead(8'h18, 32'hDEAD_BEEF, "R4 mchk mask 0");
    busRead(8'h1C, 32'h0F0F_F0F0, "R4 mchk mask 1");

    // working masks
    busWrite(8'h10, 32'h0000_0001);
    busWrite(8'h14, 32'h0000_0002);
    busWrite(8'h18, 32'h0000_0004);
    busWrite(8'h1C, 32'h0000_0001);
    repeat (2) @(negedge clk);
    checkLines(2'b00, 2'b00, "R5 idle with no source");

    // R7 latency: still low two edges after source rises, high on the third
    @(negedge clk);
    srcIrq = 32'h1;
    repeat (2) @(negedge clk);
    checkLines(2'b00, 2'b00, "R7 before third edge");
    @(negedge clk);
    checkLines(2'b01, 2'b10, "R6 shared source on irq0 and mchk1");
    busRead(8'h00, 32'h0000_0001, "R2 status bit0");

    setSrc(32'h2);
    checkLines(2'b10, 2'b00, "R5 source1 to irq1");
    setSrc(32'h4);
    checkLines(2'b00, 2'b01, "R5 source2 to mchk0");
    setSrc(32'h7);
    checkLines(2'b11, 2'b11, "R6 all outputs together");
    busRead(8'h00, 32'h0000_0007, "R2 status pattern 7");

    // R7 falling edge latency
    @(negedge clk);
    srcIrq = 32'h0;
    repeat (2) @(negedge clk);
    checkLines(2'b11, 2'b11, "R7 hold before third edge");
    @(negedge clk);
    checkLines(2'b00, 2'b00, "R7 release without ack");

    // R5 mask removal while the source stays high
    setSrc(32'h1);
    checkLines(2'b01, 2'b10, "R5 source held");
    busWrite(8'h10, 32'h0);
    checkLines(2'b01, 2'b10, "R5 one cycle after write still old");
    @(negedge clk);
    checkLines(2'b00, 2'b10, "R5 masked off");

    // R8 ignored writes
    busWrite(8'h00, 32'hFFFF_FFFF);
    busWrite(8'h20, 32'hFFFF_FFFF);
    busWrite(8'h0C, 32'hFFFF_FFFF);
    busWrite(8'h11, 32'hFFFF_FFFF);
    busWrite(8'h15, 32'hFFFF_FFFF);
    busRead(8'h00, 32'h0000_0001, "R8 status unchanged by write");
    busRead(8'h10, 32'h0000_0000, "R8 int mask 0 unchanged");
    busRead(8'h14, 32'h0000_0002, "R8 int mask 1 unchanged");
    busRead(8'h18, 32'h0000_0004, "R8 mchk mask 0 unchanged");
    busRead(8'h1C, 32'h0000_0001, "R8 mchk mask 1 unchanged");
    busRead(8'h20, 32'h0, "R8 unmapped read");
    busRead(8'h0C, 32'h0, "R8 unmapped read 0C");
    busRead(8'h11, 32'h0, "R8 unaligned read");
    repeat (2) @(negedge clk);
    checkLines(2'b00, 2'b10, "R8 lines unchanged");

    // R9 upper sources
    setSrc(32'h8001_0000);
    checkLines(2'b00, 2'b00, "R9 upper sources masked");
    busRead(8'h00, 32'h8001_0000, "R9 status upper bits");
    busWrite(8'h14, 32'h8000_0002);
    @(negedge clk);
    checkLines(2'b10, 2'b00, "R9 bit31 to irq1");
    busWrite(8'h18, 32'h0001_0000);
    @(negedge clk);
    checkLines(2'b10, 2'b01, "R9 bit16 to mchk0");

    repeat (4) @(negedge clk);
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL scoreboard: %0d reads never answered", expQ.size());
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule